// File: doc/BRIEF.md
# Dual-clock FIFO with retransmit

This block is a one-way word queue between two unrelated clock domains. A producer writes 36-bit words on its own clock and a consumer reads them on another. The queue is held in a power-of-two array. Read and write pointers cross between the domains as Gray code, through two flip-flop stages. The output behaviour is fixed at master reset. In standard mode a word appears only after a read request. In fall-through mode the oldest word is presented on the output without being asked for.

Each domain has one full-side status pin and one empty-side status pin, and their meaning follows the mode. Two threshold flags compare the fill level against offsets that another block supplies. A shared active-low control pin does one of two jobs, chosen at master reset. In one mode it is a partial reset that flushes the queue and keeps the configuration. In the other it is a retransmit that sends the read side back to the first location, so the stored data can be read again.

Top module: `dcf_rt_fifo`

## Requirements
- R1: While `rst_ni` is low, `fwft_sel_i` and `rt_mode_i` are captured. After master reset the queue is empty. In standard mode (`fwft_sel_i`=0) this gives `empty_or_o`=1, `full_ir_o`=0 and `dout_o`=0. In fall-through mode (`fwft_sel_i`=1) it gives `empty_or_o`=0 and `full_ir_o`=1. In both modes `ae_o`=1 and `af_o`=0.
- R2: In standard mode a read (`rd_i`=1 on a `rclk_i` edge while not empty) loads the oldest word into `dout_o` at that edge. Words come out in write order. A newly written word does not reach `dout_o` until it is read. In this mode `empty_or_o` is high when empty.
- R3: In standard mode the queue holds DEPTH words, and `full_ir_o` is high when DEPTH words are stored. A write while full is dropped: that word is never read back.
- R4: In standard mode a read while empty is ignored. `dout_o` holds its value and the read position does not move.
- R5: In fall-through mode the oldest word is presented on `dout_o` without a read, and `empty_or_o` (output ready) is high while a word is presented. Each read advances `dout_o` to the next word, or drops `empty_or_o` if no word is left. The presented word sits outside the array, so DEPTH+1 words fit. `full_ir_o` (input ready) is high while the array has a free location.
- R6: `ae_o` is high when the read-side count is at or below `ae_off_i`. The read-side count is the number of array words as seen by the read clock, plus one for the presented word in fall-through mode.
- R7: `af_o` is high when the write-side count is above DEPTH minus `af_off_i`. The write-side count is the number of array words as seen by the write clock.
- R8: When `rt_mode_i` was 0 at master reset, `prs_rt_ni` low resets both pointers asynchronously. It empties the queue, clears `dout_o` and keeps the captured output mode.
- R9: When `rt_mode_i` was 1 at master reset, `prs_rt_ni` low on a `rclk_i` edge sets only the read position back to the first location. In fall-through mode it also drops the presented word, and that word is then fetched again from the first location. The write position and the stored words are unchanged.
- R10: A write to an empty queue drops `empty_or_o` (standard mode) only on the second `rclk_i` rising edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, active low, asynchronous |
| prs_rt_ni | input | 1 | Partial reset or retransmit request, active low |
| fwft_sel_i | input | 1 | Output mode captured at master reset, 1 = fall-through |
| rt_mode_i | input | 1 | Control-pin role captured at master reset, 1 = retransmit |
| ae_off_i | input | $clog2(DEPTH)+1 | Almost-empty offset |
| af_off_i | input | $clog2(DEPTH)+1 | Almost-full offset |
| we_i | input | 1 | Write request |
| din_i | input | W | Write data |
| rd_i | input | 1 | Read request |
| dout_o | output | W | Read data |
| full_ir_o | output | 1 | Full (standard) or input ready (fall-through), write clock |
| af_o | output | 1 | Almost full, write clock |
| empty_or_o | output | 1 | Empty (standard) or output ready (fall-through), read clock |
| ae_o | output | 1 | Almost empty, read clock |

## Verification
The bench sweeps every fill level of a 16-deep queue in both modes and compares all four flags with counts it computes itself. A one-off error in the fall-through capacity or in a threshold compare shows up as a flag that changes one word too early or too late. It writes into a full queue and reads from an empty one. A design that let either through would return a stray word or a repeated one later in the stream. It runs both partial reset and retransmit in each mode. It checks that partial reset keeps the mode, and that retransmit replays from the first word while later writes go on from the old write position. A retransmit that moved the write side, or failed to drop the presented word, would return the wrong sequence. A one-stage synchronizer would show up in the exact edge at which the empty flag falls.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    for (int i = 0; i < 32; i++) b[i] = ^(g >> i);
    return b;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      q_o  <= '0;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int W     = 36,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl import dcf_pkg::*; #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] rgray_i,
  output logic          wr_en_o,
  output logic [AW-1:0] waddr_o,
  output logic [CW-1:0] wgray_o,
  output logic [CW-1:0] wptr_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  logic [CW-1:0] bin_q, gray_q, bin_nxt, rbin;

  assign rbin    = CW'(gray2bin(32'(rgray_i)));
  assign count_o = bin_q - rbin;
  assign full_o  = (count_o == CW'(DEPTH));
  assign wr_en_o = we_i & ~full_o;
  assign bin_nxt = bin_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (wr_en_o) begin
      bin_q  <= bin_nxt;
      gray_q <= CW'(bin2gray(32'(bin_nxt)));
    end
  end

  assign waddr_o = bin_q[AW-1:0];
  assign wgray_o = gray_q;
  assign wptr_o  = bin_q;
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl import dcf_pkg::*; #(
  parameter int W     = 36,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rt_i,
  input  logic          fwft_i,
  input  logic          rd_i,
  input  logic [CW-1:0] wgray_i,
  input  logic [W-1:0]  rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [CW-1:0] rgray_o,
  output logic [CW-1:0] rptr_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          valid_o,
  output logic [W-1:0]  dout_o
);
  logic [CW-1:0] bin_q, gray_q, bin_nxt, wbin;
  logic          valid_q;
  logic [W-1:0]  dout_q;

  assign wbin    = CW'(gray2bin(32'(wgray_i)));
  assign empty_o = (bin_q == wbin);
  assign bin_nxt = bin_q + CW'(1);
  // held fall-through word counts as stored
  assign count_o = (wbin - bin_q) + CW'(fwft_i & valid_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q   <= '0;
      gray_q  <= '0;
      valid_q <= 1'b0;
      dout_q  <= '0;
    end else if (rt_i) begin
      bin_q   <= '0;
      gray_q  <= '0;
      valid_q <= 1'b0;
    end else if (fwft_i) begin
      if ((!valid_q || rd_i) && !empty_o) begin
        dout_q  <= rdata_i;
        valid_q <= 1'b1;
        bin_q   <= bin_nxt;
        gray_q  <= CW'(bin2gray(32'(bin_nxt)));
      end else if (rd_i) begin
        valid_q <= 1'b0;
      end
    end else if (rd_i && !empty_o) begin
      dout_q <= rdata_i;
      bin_q  <= bin_nxt;
      gray_q <= CW'(bin2gray(32'(bin_nxt)));
    end
  end

  assign raddr_o = bin_q[AW-1:0];
  assign rgray_o = gray_q;
  assign rptr_o  = bin_q;
  assign valid_o = valid_q;
  assign dout_o  = dout_q;
endmodule

// File: rtl/dcf_rt_fifo.sv
module dcf_rt_fifo import dcf_pkg::*; #(
  parameter int W     = 36,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          prs_rt_ni,
  input  logic          fwft_sel_i,
  input  logic          rt_mode_i,
  input  logic [CW-1:0] ae_off_i,
  input  logic [CW-1:0] af_off_i,
  input  logic          we_i,
  input  logic [W-1:0]  din_i,
  input  logic          rd_i,
  output logic [W-1:0]  dout_o,
  output logic          full_ir_o,
  output logic          af_o,
  output logic          empty_or_o,
  output logic          ae_o
);
  logic fwft_w, rtm_w, fwft_r, rtm_r;
  logic w_rst_n, r_rst_n, rt_req;

  // configuration captured per domain while master reset is low
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwft_w <= fwft_sel_i;
      rtm_w  <= rt_mode_i;
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwft_r <= fwft_sel_i;
      rtm_r  <= rt_mode_i;
    end
  end

  assign w_rst_n = rst_ni & (rtm_w | prs_rt_ni);
  assign r_rst_n = rst_ni & (rtm_r | prs_rt_ni);
  assign rt_req  = rtm_r & ~prs_rt_ni;

  logic          wr_en, w_full, r_empty, r_valid;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] w_gray, w_ptr, w_count, rgray_s;
  logic [CW-1:0] r_gray, r_ptr, r_count, wgray_s;
  logic [W-1:0]  rdata;

  dcf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .clk_i   (wclk_i),
    .rst_ni  (w_rst_n),
    .we_i    (we_i),
    .rgray_i (rgray_s),
    .wr_en_o (wr_en),
    .waddr_o (waddr),
    .wgray_o (w_gray),
    .wptr_o  (w_ptr),
    .count_o (w_count),
    .full_o  (w_full)
  );

  dcf_sync #(.W(CW)) u_sync_r2w (
    .clk_i  (wclk_i),
    .rst_ni (w_rst_n),
    .d_i    (r_gray),
    .q_o    (rgray_s)
  );

  dcf_sync #(.W(CW)) u_sync_w2r (
    .clk_i  (rclk_i),
    .rst_ni (r_rst_n),
    .d_i    (w_gray),
    .q_o    (wgray_s)
  );

  dcf_ram #(.W(W), .DEPTH(DEPTH)) u_ram (
    .wclk_i  (wclk_i),
    .we_i    (wr_en),
    .waddr_i (waddr),
    .wdata_i (din_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  dcf_rd_ctl #(.W(W), .DEPTH(DEPTH)) u_rd (
    .clk_i   (rclk_i),
    .rst_ni  (r_rst_n),
    .rt_i    (rt_req),
    .fwft_i  (fwft_r),
    .rd_i    (rd_i),
    .wgray_i (wgray_s),
    .rdata_i (rdata),
    .raddr_o (raddr),
    .rgray_o (r_gray),
    .rptr_o  (r_ptr),
    .count_o (r_count),
    .empty_o (r_empty),
    .valid_o (r_valid),
    .dout_o  (dout_o)
  );

  assign full_ir_o  = fwft_w ? ~w_full : w_full;
  assign af_o       = (w_count > (CW'(DEPTH) - af_off_i));
  assign empty_or_o = fwft_r ? r_valid : r_empty;
  assign ae_o       = (r_count <= ae_off_i);
endmodule

// File: rtl/dcf_rt_fifo_chk.sv
module dcf_rt_fifo_chk #(
  parameter int W     = 36,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          w_rst_n,
  input logic          r_rst_n,
  input logic          we_i,
  input logic          rd_i,
  input logic          w_full,
  input logic [CW-1:0] w_ptr,
  input logic [CW-1:0] w_count,
  input logic          fwft_r,
  input logic          r_empty,
  input logic          rt_req,
  input logic [CW-1:0] r_ptr,
  input logic          r_valid,
  input logic [W-1:0]  dout_o,
  input logic [CW-1:0] r_count,
  input logic          ae_o
);
  a_r3_no_overflow: assert property (@(posedge wclk_i) disable iff (!w_rst_n)
    w_count <= CW'(DEPTH));

  a_r3_full_write_ignored: assert property (@(posedge wclk_i) disable iff (!w_rst_n)
    (w_full && we_i) |=> $stable(w_ptr));

  a_r4_empty_read_ignored: assert property (@(posedge rclk_i) disable iff (!r_rst_n)
    (!fwft_r && r_empty && rd_i && !rt_req) |=> $stable(r_ptr));

  a_r5_fwft_hold: assert property (@(posedge rclk_i) disable iff (!r_rst_n)
    (fwft_r && r_valid && !rd_i && !rt_req) |=> (r_valid && $stable(dout_o)));

  a_r6_ae_at_zero: assert property (@(posedge rclk_i) disable iff (!r_rst_n)
    (r_count == '0) |-> ae_o);

  a_r9_rt_ptr_zero: assert property (@(posedge rclk_i) disable iff (!r_rst_n)
    rt_req |=> (r_ptr == '0));
endmodule

bind dcf_rt_fifo dcf_rt_fifo_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .wclk_i  (wclk_i),
  .rclk_i  (rclk_i),
  .w_rst_n (w_rst_n),
  .r_rst_n (r_rst_n),
  .we_i    (we_i),
  .rd_i    (rd_i),
  .w_full  (w_full),
  .w_ptr   (w_ptr),
  .w_count (w_count),
  .fwft_r  (fwft_r),
  .r_empty (r_empty),
  .rt_req  (rt_req),
  .r_ptr   (r_ptr),
  .r_valid (r_valid),
  .dout_o  (dout_o),
  .r_count (r_count),
  .ae_o    (ae_o)
);

// File: tb/dcf_rt_fifo_bench.sv
module dcf_rt_fifo_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int W      = 36;
  localparam int DEPTH  = 16;
  localparam int CW     = $clog2(DEPTH) + 1;
  localparam int AE_OFF = 3;
  localparam int AF_OFF = 4;

  logic wclk, rclk, rst_n, prs_n, fwft_sel, rt_sel, we, rd;
  logic [W-1:0] din, dout;
  logic full_ir, af, empty_or, ae;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  dcf_rt_fifo #(.W(W), .DEPTH(DEPTH)) u_dcf_rt_fifo (
    .wclk_i     (wclk),
    .rclk_i     (rclk),
    .rst_ni     (rst_n),
    .prs_rt_ni  (prs_n),
    .fwft_sel_i (fwft_sel),
    .rt_mode_i  (rt_sel),
    .ae_off_i   (CW'(AE_OFF)),
    .af_off_i   (CW'(AF_OFF)),
    .we_i       (we),
    .din_i      (din),
    .rd_i       (rd),
    .dout_o     (dout),
    .full_ir_o  (full_ir),
    .af_o       (af),
    .empty_or_o (empty_or),
    .ae_o       (ae)
  );

  initial begin
    wclk = 0;
    forever #(CLK_PERIOD/2) wclk = ~wclk;
  end

  initial begin
    rclk = 0;
    #3;
    forever #(RCLK_PERIOD/2) rclk = ~rclk;
  end

  function automatic logic [W-1:0] word(input int i);
    return {4'(i), 32'hC0DE_0000 + 32'(i)};
  endfunction

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chkb(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input int rc, input int wc, input bit fw);
    chkb(req, "empty_or", empty_or, fw ? (rc > 0) : (rc == 0));
    chkb(req, "full_ir", full_ir, fw ? (wc < DEPTH) : (wc == DEPTH));
    chkb("R6", "almost_empty", ae, rc <= AE_OFF);
    chkb("R7", "almost_full", af, wc > DEPTH - AF_OFF);
  endtask

  task automatic settle;
    repeat (4) @(negedge wclk);
    repeat (4) @(negedge rclk);
  endtask

  task automatic mreset(input bit fw, input bit rt);
    we = 0; rd = 0; prs_n = 1;
    fwft_sel = fw; rt_sel = rt;
    rst_n = 0;
    repeat (3) @(negedge wclk);
    rst_n = 1;
    settle();
  endtask

  task automatic write_word(input logic [W-1:0] d);
    @(negedge wclk);
    we = 1; din = d;
    @(negedge wclk);
    we = 0;
  endtask

  task automatic read_word;
    @(negedge rclk);
    rd = 1;
    @(negedge rclk);
    rd = 0;
  endtask

  task automatic partial_pulse;
    @(negedge wclk);
    prs_n = 0;
    #3;
    prs_n = 1;
  endtask

  task automatic rt_pulse;
    @(negedge rclk);
    prs_n = 0;
    @(negedge rclk);
    prs_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; prs_n = 1; we = 0; rd = 0; din = '0;
    fwft_sel = 0; rt_sel = 0;

    // standard mode, reset state
    mreset(0, 0);
    chkb("R1", "std empty", empty_or, 1'b1);
    chkb("R1", "std full", full_ir, 1'b0);
    chkb("R1", "std ae", ae, 1'b1);
    chkb("R1", "std af", af, 1'b0);
    chk("R1", "std dout", dout, '0);

    // R3 fill sweep, flags at every level
    for (int n = 1; n <= DEPTH; n++) begin
      write_word(word(n - 1));
      settle();
      chk_flags("R3", n, n, 0);
    end
    write_word(word(99));
    settle();
    chk_flags("R3", DEPTH, DEPTH, 0);

    // R2 drain in order; dropped word never appears
    for (int k = 0; k < DEPTH; k++) begin
      read_word();
      chk("R2", "std order", dout, word(k));
      settle();
      chk_flags("R2", DEPTH - 1 - k, DEPTH - 1 - k, 0);
    end
    read_word();
    chk("R3", "dropped word absent", dout, word(DEPTH - 1));

    // R2 first word needs an explicit read
    write_word(word(100));
    settle();
    chk("R2", "no auto present", dout, word(DEPTH - 1));
    chkb("R2", "not empty", empty_or, 1'b0);
    read_word();
    chk("R2", "first word read", dout, word(100));

    // R4 read while empty
    read_word();
    chk("R4", "dout held", dout, word(100));
    chkb("R4", "still empty", empty_or, 1'b1);
    write_word(word(101));
    settle();
    read_word();
    chk("R4", "ptr not advanced", dout, word(101));

    // R10 two-stage sync latency
    settle();
    @(negedge wclk);
    we = 1; din = word(102);
    @(posedge wclk);
    we <= 1'b0;
    @(posedge rclk);
    #1;
    chkb("R10", "empty after 1 edge", empty_or, 1'b1);
    @(posedge rclk);
    #1;
    chkb("R10", "empty after 2 edges", empty_or, 1'b0);
    read_word();
    chk("R10", "word", dout, word(102));

    // R8 partial reset in standard mode
    for (int k = 0; k < 3; k++) write_word(word(200 + k));
    settle();
    chkb("R8", "filled", empty_or, 1'b0);
    partial_pulse();
    settle();
    chk_flags("R8", 0, 0, 0);
    chk("R8", "dout cleared", dout, '0);
    write_word(word(203));
    settle();
    chk("R8", "still standard", dout, '0);
    read_word();
    chk("R8", "pointers at start", dout, word(203));

    // fall-through mode
    mreset(1, 0);
    chkb("R1", "fwft ready", empty_or, 1'b0);
    chkb("R1", "fwft input ready", full_ir, 1'b1);
    chkb("R1", "fwft ae", ae, 1'b1);
    chkb("R1", "fwft af", af, 1'b0);
    for (int n = 1; n <= DEPTH + 1; n++) begin
      write_word(word(300 + n - 1));
      settle();
      chk_flags("R5", n, n - 1, 1);
      if (n == 1) chk("R5", "auto present", dout, word(300));
    end
    write_word(word(399));
    settle();
    chk_flags("R5", DEPTH + 1, DEPTH, 1);
    for (int k = 0; k <= DEPTH; k++) begin
      chk("R5", "fwft order", dout, word(300 + k));
      read_word();
    end
    settle();
    chk_flags("R5", 0, 0, 1);

    // R8 partial reset keeps fall-through mode
    partial_pulse();
    settle();
    chkb("R8", "fwft ready low", empty_or, 1'b0);
    chkb("R8", "fwft input ready", full_ir, 1'b1);
    write_word(word(400));
    settle();
    chk("R8", "fwft kept", dout, word(400));
    chkb("R8", "fwft ready", empty_or, 1'b1);

    // R9 retransmit, standard mode
    mreset(0, 1);
    for (int k = 0; k < 5; k++) write_word(word(500 + k));
    settle();
    for (int k = 0; k < 3; k++) begin
      read_word();
      chk("R9", "pre read", dout, word(500 + k));
    end
    rt_pulse();
    settle();
    chk_flags("R9", 5, 5, 0);
    for (int k = 0; k < 5; k++) begin
      read_word();
      chk("R9", "replay", dout, word(500 + k));
    end
    write_word(word(505));
    settle();
    read_word();
    chk("R9", "write ptr kept", dout, word(505));

    // R9 retransmit, fall-through mode
    mreset(1, 1);
    for (int k = 0; k < 3; k++) write_word(word(600 + k));
    settle();
    chk("R9", "fwft first", dout, word(600));
    read_word();
    read_word();
    chk("R9", "fwft third", dout, word(602));
    rt_pulse();
    settle();
    chk("R9", "fwft replay", dout, word(600));
    chkb("R9", "fwft ready", empty_or, 1'b1);
    read_word();
    chk("R9", "fwft replay next", dout, word(601));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule